// File: doc/BRIEF.md
# Shared-Vector Interrupt Router

This block collects seven level-sensitive interrupt inputs and steers each one onto one of six output interrupt lines. Every input passes through a vector register. The register holds a destination server number, a priority and a 3-bit output line selector. The first two inputs (the host-link input and the service-processor input) share vector 0. Each of the remaining five inputs has a vector of its own, numbered 1 to 5. Vector 0 counts as asserted while either of its two inputs is high, so its line stays up until both are low.

Each vector also carries a pending bit. The pending bit is re-evaluated only when an input of that vector changes level. It is set when the vector is asserted and its priority is not 0xFF; 0xFF is the masked encoding. Software reaches the vectors through a simple register port: writes take effect on the clock edge and reads are combinational.

After every accepted vector write, the block publishes the written server number, with its two link-pointer bits dropped, and the written priority. A downstream presentation controller uses these values. Acknowledge handling is outside this block.

Top module: `irq_vector_mux`

## Requirements
- R1: One cycle after an input change, the status word read at index 6 shows the registered inputs: input 0 at bit 47, input 1 at bit 46, and inputs 2..6 at bits 36..32 (input 2 at bit 36). All other bits read 0.
- R2: After reset, vector v (0..5) reads server 0, priority 0xFF, line field v and pending 0. All lines are low and cfg_valid and wr_err are 0.
- R3: Output line k is high when a vector whose line field equals k is asserted in the registered status. Vector 0 is asserted when input 0 or input 1 is high; vector v (1..5) follows input v+1. A line field of 6 or 7 drives no line. Masking does not block a line.
- R4: When several asserted vectors select the same line, that line is the OR of them.
- R5: In a cycle where an input of a vector changes level, that vector's pending bit becomes (new asserted state AND priority != 0xFF). In all other cycles it keeps its value, except as R7 says.
- R6: When one input of the shared vector 0 falls while the other stays high, line and pending are evaluated as asserted. Both inputs must be low before the line drops.
- R7: A write to index v (0..5) replaces server (wdata[55:40]), priority (wdata[39:32]) and line field (wdata[31:29]). It keeps the pending bit unless the new priority is 0xFF, in which case pending is cleared.
- R8: When a write and an input edge hit the same vector in the same cycle, the pending evaluation uses the newly written priority.
- R9: One cycle after a write to index 0..5 whose line field is below 6, cfg_valid is 1 for one cycle and cfg_server/cfg_prio hold wdata[55:42]/wdata[39:32]. A write with line field 6 or 7 is stored but leaves cfg_valid at 0 and the cfg outputs unchanged.
- R10: A write to index 6 or 7 changes no vector or status state and raises wr_err for exactly the following cycle.
- R11: A vector reads back as server at [55:40], priority at [39:32], line field at [31:29] and pending at bit 24, with all other bits 0. Indices 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | 7 | Level interrupt inputs, index 0..6 |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index: 0..5 vectors, 6 status |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Combinational read data for reg_idx |
| irq_line | output | 6 | Level output interrupt lines |
| cfg_valid | output | 1 | One-cycle strobe after an accepted vector write |
| cfg_server | output | 14 | Last accepted server number, link bits dropped |
| cfg_prio | output | 8 | Last accepted priority |
| wr_err | output | 1 | One-cycle flag after a write to an invalid index |

## Verification
The two functions that can fall in the same cycle are a vector write and a level change on an input of the same vector. This matters most when the write moves the priority to or from 0xFF. The bench provokes the collision on purpose: it unmasks a masked vector in the very cycle its input rises, and it also changes a shared-vector input while that vector is rewritten. The bench then reads the pending bit back and compares it with a model that applies the write first and then the edge evaluation. The random phase issues writes and input toggles on independent draws, so the two often coincide on other vectors too.

// File: rtl/irq_vector_mux.sv
module irq_vector_mux #(
  parameter int NSRC  = 7,
  parameter int SRVW  = 16,
  parameter int PRIOW = 8,
  parameter int LNW   = 3,
  parameter int AW    = 3,
  parameter int DW    = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSRC-1:0]    src_lvl,
  input  logic               reg_we,
  input  logic [AW-1:0]      reg_idx,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  output logic [NSRC-2:0]    irq_line,
  output logic               cfg_valid,
  output logic [SRVW-3:0]    cfg_server,
  output logic [PRIOW-1:0]   cfg_prio,
  output logic               wr_err
);
  localparam int NVEC     = NSRC - 1;
  localparam int NLINE    = NVEC;
  localparam int SRV_LSB  = 40;
  localparam int PRIO_LSB = 32;
  localparam int LN_LSB   = 29;
  localparam int PEND_BIT = 24;

  logic [NSRC-1:0]             stat;
  logic [NVEC-1:0][SRVW-1:0]   srv;
  logic [NVEC-1:0][PRIOW-1:0]  prio;
  logic [NVEC-1:0][LNW-1:0]    ln;
  logic [NVEC-1:0]             pend;
  logic [NVEC-1:0]             st_q, st_in, edg, hit, pend_nx;
  logic [NVEC-1:0][PRIOW-1:0]  prio_nx;

  wire              wr_ok  = reg_we && (reg_idx < AW'(NVEC));
  wire [SRVW-1:0]   w_srv  = reg_wdata[SRV_LSB +: SRVW];
  wire [PRIOW-1:0]  w_prio = reg_wdata[PRIO_LSB +: PRIOW];
  wire [LNW-1:0]    w_ln   = reg_wdata[LN_LSB +: LNW];

  for (genvar v = 0; v < NVEC; v++) begin : g_vec
    if (v == 0) begin : g_pair
      assign st_q[v]  = stat[0] | stat[1];
      assign st_in[v] = src_lvl[0] | src_lvl[1];
      assign edg[v]   = |(src_lvl[1:0] ^ stat[1:0]);
    end else begin : g_single
      assign st_q[v]  = stat[v+1];
      assign st_in[v] = src_lvl[v+1];
      assign edg[v]   = src_lvl[v+1] ^ stat[v+1];
    end
    assign hit[v]     = wr_ok && (reg_idx == AW'(v));
    assign prio_nx[v] = hit[v] ? w_prio : prio[v];
    assign pend_nx[v] = edg[v] ? (st_in[v] & ~(&prio_nx[v])) : (pend[v] & ~(&prio_nx[v]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        srv[v]  <= '0;
        prio[v] <= '1;
        ln[v]   <= LNW'(v);
        pend[v] <= 1'b0;
      end else begin
        if (hit[v]) begin
          srv[v] <= w_srv;
          ln[v]  <= w_ln;
        end
        prio[v] <= prio_nx[v];
        pend[v] <= pend_nx[v];
      end
    end

    p_pend_unmasked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pend[v] |-> !(&prio[v]));
    p_write_keeps_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[v] && !(&w_prio) && !edg[v]) |=> (pend[v] == $past(pend[v])));
  end

  always_comb begin
    irq_line = '0;
    for (int k = 0; k < NLINE; k++)
      for (int v = 0; v < NVEC; v++)
        if (st_q[v] && ln[v] == LNW'(k)) irq_line[k] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat       <= '0;
      cfg_valid  <= 1'b0;
      cfg_server <= '0;
      cfg_prio   <= '0;
      wr_err     <= 1'b0;
    end else begin
      stat      <= src_lvl;
      wr_err    <= reg_we && !wr_ok;
      cfg_valid <= wr_ok && (w_ln < LNW'(NLINE));
      if (wr_ok && (w_ln < LNW'(NLINE))) begin
        cfg_server <= w_srv[SRVW-1:2];
        cfg_prio   <= w_prio;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_idx < AW'(NVEC)) begin
      for (int v = 0; v < NVEC; v++)
        if (reg_idx == AW'(v)) begin
          reg_rdata[SRV_LSB +: SRVW]   = srv[v];
          reg_rdata[PRIO_LSB +: PRIOW] = prio[v];
          reg_rdata[LN_LSB +: LNW]     = ln[v];
          reg_rdata[PEND_BIT]          = pend[v];
        end
    end else if (reg_idx == AW'(NVEC)) begin
      reg_rdata[47] = stat[0];
      reg_rdata[46] = stat[1];
      for (int i = 2; i < NSRC; i++) reg_rdata[38-i] = stat[i];
    end
  end

  p_cfg_server_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> (cfg_server == $past(reg_wdata[SRV_LSB+SRVW-1:SRV_LSB+2])));
  p_bad_idx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> ($stable(srv) && $stable(prio) && $stable(ln)));
  p_pair_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stat[0]) && stat[1] && (ln[0] < LNW'(NLINE))) |-> |(irq_line & (NLINE'(1) << ln[0])));
endmodule

// File: tb/irq_vector_mux_bench.sv
module irq_vector_mux_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  src_lvl = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic [5:0]  irq_line;
  logic        cfg_valid, wr_err;
  logic [13:0] cfg_server;
  logic [7:0]  cfg_prio;

  irq_vector_mux u_irq_vector_mux (.*);

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [6:0]  m_stat;
  logic [15:0] m_srv [6];
  logic [7:0]  m_prio[6];
  logic [2:0]  m_ln  [6];
  logic        m_pend[6];
  logic        m_cv, m_err;
  logic [13:0] m_cs;
  logic [7:0]  m_cp;

  task automatic model_reset();
    m_stat = '0; m_cv = 0; m_err = 0; m_cs = '0; m_cp = '0;
    for (int v = 0; v < 6; v++) begin
      m_srv[v] = '0; m_prio[v] = 8'hFF; m_ln[v] = 3'(v); m_pend[v] = 0;
    end
  endtask

  task automatic model_step(logic [6:0] in, logic we, logic [2:0] idx, logic [63:0] wd);
    for (int v = 0; v < 6; v++) begin
      logic st, ed, mk;
      st = (v == 0) ? (in[0] | in[1]) : in[v+1];
      ed = (v == 0) ? (in[1:0] != m_stat[1:0]) : (in[v+1] != m_stat[v+1]);
      if (we && idx == 3'(v)) begin
        m_srv[v] = wd[55:40]; m_prio[v] = wd[39:32]; m_ln[v] = wd[31:29];
      end
      mk = &m_prio[v];
      m_pend[v] = ed ? (st && !mk) : (m_pend[v] && !mk);
    end
    m_stat = in;
    m_err = we && idx >= 3'd6;
    m_cv = we && idx < 3'd6 && wd[31:29] < 3'd6;
    if (m_cv) begin m_cs = wd[55:42]; m_cp = wd[39:32]; end
  endtask

  function automatic logic [5:0] exp_line();
    logic [5:0] l = '0;
    for (int v = 0; v < 6; v++) begin
      logic st = (v == 0) ? (m_stat[0] | m_stat[1]) : m_stat[v+1];
      if (st && m_ln[v] < 3'd6) l[m_ln[v]] = 1'b1;
    end
    return l;
  endfunction

  function automatic logic [63:0] exp_rd(logic [2:0] idx);
    logic [63:0] w = '0;
    if (idx < 3'd6) begin
      w[55:40] = m_srv[idx]; w[39:32] = m_prio[idx]; w[31:29] = m_ln[idx]; w[24] = m_pend[idx];
    end else if (idx == 3'd6) begin
      w[47] = m_stat[0]; w[46] = m_stat[1];
      for (int i = 2; i < 7; i++) w[38-i] = m_stat[i];
    end
    return w;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic [6:0] in, logic we, logic [2:0] idx, logic [63:0] wd);
    @(negedge clk);
    src_lvl = in; reg_we = we; reg_idx = idx; reg_wdata = wd;
    @(posedge clk);
    model_step(in, we, idx, wd);
    #1;
    reg_we = 0;
    chk("R3 R4 lines", 64'(irq_line), 64'(exp_line()));
    chk("R9 cfg_valid", 64'(cfg_valid), 64'(m_cv));
    chk("R9 cfg_server", 64'(cfg_server), 64'(m_cs));
    chk("R9 cfg_prio", 64'(cfg_prio), 64'(m_cp));
    chk("R10 wr_err", 64'(wr_err), 64'(m_err));
  endtask

  task automatic rd(string tag, logic [2:0] idx);
    reg_idx = idx;
    #1;
    chk(tag, reg_rdata, exp_rd(idx));
  endtask

  function automatic logic [63:0] vw(logic [15:0] s, logic [7:0] p, logic [2:0] l);
    return {8'h00, s, p, l, 29'h0};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R2 lines at reset", 64'(irq_line), 64'h0);
    chk("R2 cfg_valid at reset", 64'(cfg_valid), 64'h0);
    for (int v = 0; v < 8; v++) rd("R2 R11 reset readback", 3'(v));
    rst_n = 1;

    step(7'b0000100, 0, 0, 0);
    rd("R1 status word", 3'd6);
    rd("R5 masked pending stays 0", 3'd1);
    step(7'b0000100, 1, 3'd1, vw(16'h1235, 8'h10, 3'd1));
    chk("R9 server shifted", 64'(cfg_server), 64'h48D);
    rd("R7 write keeps pending 0", 3'd1);
    step(7'b0000000, 0, 0, 0);
    step(7'b0000100, 0, 0, 0);
    rd("R5 pending set on edge", 3'd1);
    step(7'b0000100, 1, 3'd1, vw(16'h0004, 8'h20, 3'd1));
    rd("R7 write keeps pending 1", 3'd1);
    step(7'b0000100, 1, 3'd1, vw(16'h0004, 8'hFF, 3'd1));
    rd("R7 masking write clears pending", 3'd1);

    step(7'b0000100, 1, 3'd0, vw(16'h0100, 8'h05, 3'd0));
    step(7'b0000111, 0, 0, 0);
    step(7'b0000110, 0, 0, 0);
    chk("R6 shared line held", 64'(irq_line[0]), 64'h1);
    rd("R6 shared pending held", 3'd0);
    step(7'b0000100, 0, 0, 0);
    chk("R6 shared line drops", 64'(irq_line[0]), 64'h0);
    rd("R6 shared pending drops", 3'd0);

    step(7'b0000100, 0, 0, 0);
    step(7'b0001100, 1, 3'd2, vw(16'h0008, 8'h30, 3'd2));
    rd("R8 unmask and edge same cycle", 3'd2);
    step(7'b0001101, 1, 3'd0, vw(16'h0100, 8'hFF, 3'd0));
    rd("R8 mask and edge same cycle", 3'd0);

    step(7'b0001100, 1, 3'd6, vw(16'hFFFF, 8'h00, 3'd0));
    rd("R10 vector 0 unchanged", 3'd0);
    step(7'b0001100, 1, 3'd7, vw(16'hFFFF, 8'h00, 3'd0));
    rd("R10 status unchanged", 3'd6);

    step(7'b0001100, 1, 3'd1, vw(16'h00F0, 8'h11, 3'd7));
    chk("R3 line field 7 drives nothing", 64'(irq_line[1]), 64'h0);
    step(7'b0001100, 1, 3'd2, vw(16'h00F0, 8'h11, 3'd4));
    step(7'b1001100, 1, 3'd5, vw(16'h0000, 8'h40, 3'd4));
    chk("R4 shared output line", 64'(irq_line[4]), 64'h1);
    step(7'b1000100, 0, 0, 0);
    chk("R4 line held by other vector", 64'(irq_line[4]), 64'h1);

    for (int n = 0; n < 3000; n++) begin
      logic [6:0] in;
      logic we;
      logic [2:0] idx;
      logic [7:0] p;
      in = src_lvl;
      for (int b = 0; b < 7; b++) if ($urandom_range(0, 5) == 0) in[b] = ~in[b];
      we = ($urandom_range(0, 3) == 0);
      idx = 3'($urandom_range(0, 7));
      p = ($urandom_range(0, 2) == 0) ? 8'hFF : 8'($urandom);
      step(in, we, idx, vw(16'($urandom), p, 3'($urandom_range(0, 7))));
      rd("R1 R5 R7 R8 R11 random readback", 3'($urandom_range(0, 7)));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule